// File: doc/BRIEF.md
# Serial-Input Interrupt Sense Unit

This block turns the input values of a serial expander into interrupt requests. Once per serial frame, the shifting engine presents a freshly captured vector of pin values together with a one-cycle strobe. On each strobe, the unit compares every pin against the value captured on the previous strobe and against the pin's programmed trigger mode. Enabled pins that match latch a sticky status bit. A single interrupt line toward the host is raised while any pin has both its status bit and its enable bit set.

Configuration arrives over a simple single-cycle write port. The pins are grouped into 32-bit banks. Each bank has its own enable word, three trigger-type words and a status word that is cleared by writing ones. Software reads the status through a flat status vector, acknowledges pins by writing ones to the status word, and masks pins through the enable word.

Top module: `pin_irq_sense`

## Requirements
- R1: After reset, every status bit and the interrupt output are 0, and all enable and type bits are 0, so frames raise no status until software configures a pin.
- R2: A pin whose enable bit is 0 gains no new status bit. A status bit that is already set stays set when its enable is cleared, but it no longer drives the interrupt.
- R3: When a pin's type2 bit is 1, a change of value between two consecutive frames (0 to 1 or 1 to 0) sets its status, whatever type0 and type1 hold. A repeated value does not.
- R4: With type2=0 and type1=0 the pin is edge sensitive. type0=1 selects a 0 to 1 change and type0=0 selects a 1 to 0 change between consecutive frames.
- R5: With type2=0 and type1=1 the pin is level sensitive. type0=1 triggers on a frame value of 1 and type0=0 on a frame value of 0. If the level persists after a clear, the status sets again on the next frame.
- R6: Detection happens only in a cycle where frame_valid is 1. Input changes between strobes are ignored. Edges compare against the value captured at the last strobe, which is 0 after reset.
- R7: Writing to the status word clears each bit written as 1. Bits written as 0, and bits of other banks, are unchanged. A status write never sets a bit.
- R8: If a clear and a new detection hit the same bit in the same cycle, the bit is 1 afterwards.
- R9: irq_o is the OR over all pins of status AND enable, with no added cycle of delay.
- R10: The write port uses wr_sel codes 0=enable, 1=type0, 2=type1, 3=type2 and 4=status (write-one-to-clear). Bit k of wr_data addresses pin wr_bank*32+k. Writes with codes 5 to 7, to a bank index with no pins, or to bits above the last pin have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe marking a newly captured frame |
| frame_vals | input | NUM_PINS | Captured pin values, valid when frame_valid is 1 |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | BSEL_W | Bank index of the write |
| wr_sel | input | 3 | Register select code of the write |
| wr_data | input | BANK_W | Write data, one bit per pin of the bank |
| status_o | output | NUM_PINS | Sticky per-pin interrupt status |
| irq_o | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check several status rules. A bit written as one and not re-detected ends up clear. A detection hit always lands in the status, even under a same-cycle clear. No status bit appears without a hit. No status bit appears for a pin that was disabled on the strobe. The interrupt never rises while the status is empty. The trigger-mode decode can only be shown by the bench, which drives each type combination through a table of previous and current frame values on pins spread across all three banks. The bench also covers several ordered scenarios: values changed between strobes, level re-triggering after acknowledge, interrupt masking while status is held, and writes to unused codes or banks.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic [2:0] {
    SEL_ENABLE = 3'd0,
    SEL_TYPE0  = 3'd1,
    SEL_TYPE1  = 3'd2,
    SEL_TYPE2  = 3'd3,
    SEL_STATUS = 3'd4
  } reg_sel_e;

  // Trigger decision for one pin given its mode bits and two frame samples.
  function automatic logic pin_trigger(input logic t0, input logic t1,
                                       input logic t2, input logic prev,
                                       input logic cur);
    if (t2) return prev ^ cur;
    if (t1) return cur == t0;
    return t0 ? (!prev && cur) : (prev && !cur);
  endfunction

endpackage

// File: rtl/pin_irq_cfg.sv
module pin_irq_cfg
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS  = 80,
  parameter int BANK_W    = 32,
  parameter int BSEL_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [BSEL_W-1:0]   wr_bank,
  input  logic [2:0]          wr_sel,
  input  logic [BANK_W-1:0]   wr_data,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] ty0_o,
  output logic [NUM_PINS-1:0] ty1_o,
  output logic [NUM_PINS-1:0] ty2_o,
  output logic [NUM_PINS-1:0] clr_o
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int B = p / BANK_W;
    localparam int K = p % BANK_W;

    logic bank_hit;
    logic en_q, t0_q, t1_q, t2_q;

    assign bank_hit = wr_en && (wr_bank == BSEL_W'(B));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b0;
        t0_q <= 1'b0;
        t1_q <= 1'b0;
        t2_q <= 1'b0;
      end else if (bank_hit) begin
        case (wr_sel)
          SEL_ENABLE: en_q <= wr_data[K];
          SEL_TYPE0:  t0_q <= wr_data[K];
          SEL_TYPE1:  t1_q <= wr_data[K];
          SEL_TYPE2:  t2_q <= wr_data[K];
          default: ;
        endcase
      end
    end

    assign en_o[p]  = en_q;
    assign ty0_o[p] = t0_q;
    assign ty1_o[p] = t1_q;
    assign ty2_o[p] = t2_q;
    assign clr_o[p] = bank_hit && (wr_sel == SEL_STATUS) && wr_data[K];
  end

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_valid,
  input  logic [NUM_PINS-1:0] frame_vals,
  input  logic [NUM_PINS-1:0] en,
  input  logic [NUM_PINS-1:0] ty0,
  input  logic [NUM_PINS-1:0] ty1,
  input  logic [NUM_PINS-1:0] ty2,
  output logic [NUM_PINS-1:0] hit_o
);

  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           prev_q <= '0;
    else if (frame_valid) prev_q <= frame_vals;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_det
    assign hit_o[p] = frame_valid && en[p] &&
                      pin_trigger(ty0[p], ty1[p], ty2[p], prev_q[p], frame_vals[p]);
  end

endmodule

// File: rtl/pin_irq_status.sv
module pin_irq_status #(
  parameter int NUM_PINS = 80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] hit,
  input  logic [NUM_PINS-1:0] clr,
  output logic [NUM_PINS-1:0] status_o
);

  logic [NUM_PINS-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr) | hit;
  end

  assign status_o = status_q;

  // R7: a cleared bit without a fresh hit is gone on the next cycle
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~hit)) |=> ((status_q & $past(clr & ~hit)) == '0));

  // R8: a hit always lands, even under a same-cycle clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & clr)) |=> ((status_q & $past(hit & clr)) == $past(hit & clr)));

  // R7: no status bit appears without a detection hit
  a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |=> ((status_q & ~$past(status_q)) == '0));

endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS  = 80,
  parameter int BANK_W    = 32,
  parameter int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W,
  parameter int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_valid,
  input  logic [NUM_PINS-1:0] frame_vals,
  input  logic                wr_en,
  input  logic [BSEL_W-1:0]   wr_bank,
  input  logic [2:0]          wr_sel,
  input  logic [BANK_W-1:0]   wr_data,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0] en_w, ty0_w, ty1_w, ty2_w, clr_w, hit_w, status_w;

  pin_irq_cfg #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .BSEL_W(BSEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_sel(wr_sel), .wr_data(wr_data),
    .en_o(en_w), .ty0_o(ty0_w), .ty1_o(ty1_w), .ty2_o(ty2_w), .clr_o(clr_w)
  );

  pin_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
    .frame_vals(frame_vals), .en(en_w), .ty0(ty0_w), .ty1(ty1_w),
    .ty2(ty2_w), .hit_o(hit_w)
  );

  pin_irq_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .clr(clr_w), .status_o(status_w)
  );

  assign status_o = status_w;
  assign irq_o    = |(status_w & en_w);

  // R2: after a strobe, new status bits only on pins that were enabled
  a_r2_gate_by_enable: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> (((status_w & ~$past(status_w)) & ~$past(en_w)) == '0));

  // R9: the merged request needs some pending status
  a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_w != '0));

  // R9: a hit that is not masked right away raises the request
  a_r9_hit_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit_w) && !(wr_en && wr_sel == SEL_ENABLE)) |=> irq_o);

endmodule

// File: tb/pin_irq_sense_bench.sv
module pin_irq_sense_bench;

  localparam int CLK_P = 10;
  localparam int NP    = 80;
  localparam logic [NP-1:0] ONE = 1;

  // entry: {t2,t1,t0, prev, cur, expected}
  localparam int NV = 13;
  localparam logic [5:0] VEC [NV] = '{
    6'b100_01_1, 6'b100_10_1, 6'b100_11_0,
    6'b001_01_1, 6'b001_10_0,
    6'b000_10_1, 6'b000_01_0,
    6'b011_11_1, 6'b011_00_0,
    6'b010_00_1, 6'b010_11_0,
    6'b111_11_0, 6'b111_01_1
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_valid = 1'b0;
  logic [NP-1:0] frame_vals = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_bank = '0;
  logic [2:0]    wr_sel = '0;
  logic [31:0]   wr_data = '0;
  logic [NP-1:0] status_o;
  logic          irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pin_irq_sense u_pin_irq_sense (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
    .frame_vals(frame_vals), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_sel(wr_sel), .wr_data(wr_data), .status_o(status_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s status act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s irq act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic do_wr(input int bank, input int sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = 2'(bank); wr_sel = 3'(sel); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_frame(input logic [NP-1:0] v);
    @(negedge clk);
    frame_valid = 1'b1; frame_vals = v;
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic do_both(input logic [NP-1:0] v, input int bank, input logic [31:0] data);
    @(negedge clk);
    frame_valid = 1'b1; frame_vals = v;
    wr_en = 1'b1; wr_bank = 2'(bank); wr_sel = 3'd4; wr_data = data;
    @(negedge clk);
    frame_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic clear_bank_cfg(input int bank);
    for (int s = 0; s < 4; s++) do_wr(bank, s, 32'h0);
    do_wr(bank, 4, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset status", status_o, '0);
    chk1("R1 reset irq", irq_o, 1'b0);
    rst_n = 1'b1;
    do_frame({NP{1'b1}});
    do_frame('0);
    chk("R1 unconfigured frames", status_o, '0);

    // table walk: R3 / R4 / R5 decode across banks
    for (int i = 0; i < NV; i++) begin
      int p = (i * 7 + 3) % NP;
      int b = p / 32;
      logic [31:0] m = 32'd1 << (p % 32);
      logic [5:0] e = VEC[i];
      string tag = e[5] ? "R3 both-edge" : (e[4] ? "R5 level" : "R4 edge");
      do_frame(e[2] ? (ONE << p) : '0);
      do_wr(b, 3, e[5] ? m : 32'h0);
      do_wr(b, 2, e[4] ? m : 32'h0);
      do_wr(b, 1, e[3] ? m : 32'h0);
      do_wr(b, 0, m);
      do_frame(e[1] ? (ONE << p) : '0);
      chk(tag, status_o, e[0] ? (ONE << p) : '0);
      chk1(tag, irq_o, e[0]);
      clear_bank_cfg(b);
    end

    // R6: strobe-only sampling, pin 40 rising edge
    do_frame('0);
    do_wr(1, 1, 32'h100);
    do_wr(1, 0, 32'h100);
    @(negedge clk); frame_vals = ONE << 40;
    repeat (3) @(negedge clk);
    chk("R6 no strobe no status", status_o, '0);
    do_frame('0);
    chk("R6 glitch between strobes ignored", status_o, '0);
    do_frame(ONE << 40);
    chk("R6 edge on strobe", status_o, ONE << 40);
    chk1("R9 irq with pending enabled", irq_o, 1'b1);

    // R7: write-one-to-clear
    do_wr(1, 4, 32'h0);
    chk("R7 zero write keeps", status_o, ONE << 40);
    do_wr(0, 4, 32'hFFFF_FFFF);
    chk("R7 other bank keeps", status_o, ONE << 40);
    do_wr(1, 4, 32'h100);
    chk("R7 one clears", status_o, '0);
    chk1("R7 irq drops", irq_o, 1'b0);
    do_wr(1, 4, 32'h200);
    chk("R7 clear never sets", status_o, '0);

    // R2 / R9: masking
    do_frame('0);
    do_frame(ONE << 40);
    do_wr(1, 0, 32'h0);
    chk("R2 status kept when disabled", status_o, ONE << 40);
    chk1("R9 irq masked", irq_o, 1'b0);
    do_wr(1, 0, 32'h100);
    chk1("R9 irq back on enable", irq_o, 1'b1);
    do_wr(1, 4, 32'h100);
    do_wr(1, 0, 32'h0);
    do_frame('0);
    do_frame(ONE << 40);
    chk("R2 disabled pin no status", status_o, '0);
    clear_bank_cfg(1);

    // R5: level re-trigger, pin 75 high level
    do_wr(2, 2, 32'h800);
    do_wr(2, 1, 32'h800);
    do_wr(2, 0, 32'h800);
    do_frame(ONE << 75);
    chk("R5 level sets", status_o, ONE << 75);
    do_wr(2, 4, 32'h800);
    chk("R5 cleared", status_o, '0);
    do_frame(ONE << 75);
    chk("R5 level sets again", status_o, ONE << 75);

    // R8: clear and detection together
    do_both(ONE << 75, 2, 32'h800);
    chk("R8 set wins", status_o, ONE << 75);
    do_both('0, 2, 32'h800);
    chk("R8 clear alone", status_o, '0);
    clear_bank_cfg(2);

    // R10: bank mapping of last pin, then ignored writes
    do_wr(2, 3, 32'h8000);
    do_wr(2, 0, 32'h8000);
    do_frame('0);
    do_frame(ONE << 79);
    chk("R10 pin 79 in bank 2 bit 15", status_o, ONE << 79);
    clear_bank_cfg(2);
    do_wr(3, 3, 32'hFFFF_FFFF);
    do_wr(3, 0, 32'hFFFF_FFFF);
    for (int s = 5; s < 8; s++) do_wr(0, s, 32'hFFFF_FFFF);
    do_frame({NP{1'b1}});
    do_frame('0);
    chk("R10 unused bank and codes ignored", status_o, '0);
    chk1("R10 irq stays low", irq_o, 1'b0);

    // R1: reset clears configuration
    do_wr(0, 3, 32'h1);
    do_wr(0, 0, 32'h1);
    do_frame(ONE);
    chk("R1 pre-reset status", status_o, ONE);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears status", status_o, '0);
    rst_n = 1'b1;
    do_frame('0);
    do_frame(ONE);
    chk("R1 reset clears enable/type", status_o, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule